// File: doc/BRIEF.md
# Vectored Interrupt Acknowledge Responder

This block is the card-side logic of a peripheral that supplies its own interrupt vector during a hardware-arbitrated acknowledge. Software loads an 8-bit vector, picks one of the two supported interrupt levels and turns vectored mode on. A request pulse from the card's function logic marks an interrupt as pending. The block then pulls the matching interrupt line low.

When the bus controller runs a CPU-space acknowledge cycle, the block works through it in two steps. In the first step the controller polls the cards, and the block claims the cycle if the level on the address lines is its own. In the second step the controller selects one claimant. If the block is selected, it drives its vector onto byte lane 15..8 of the data bus and acknowledges the transfer. That response also retires the pending interrupt. With vectored mode off, the block never claims a cycle, so the interrupt is left to autovectoring.

Bus outputs that are shared on the physical bus are presented as a value plus an output enable. The pad buffers live outside the block.

Top module: `vecirq_responder`

## Requirements
- R1: After synchronous reset, no interrupt is pending and vectored mode is off. Both interrupt lines, `claim_n` and `ack_n` are high. `data_oe` and `ack_oe` are low and `data_o` is zero.
- R2: The register port decodes `reg_addr` as follows. Address 0 loads the vector from `reg_wdata`. Address 1 loads the control bits: bit 0 turns vectored mode on, and bit 1 selects the level (0 for level 2 on `int2_n`, 1 for level 6 on `int6_n`). Address 2 clears the pending interrupt whatever the data. A write to address 3 changes nothing.
- R3: A pulse on `irq_req` makes the interrupt pending from the next cycle. The selected interrupt line goes low in that same cycle and the other line stays high. A clear in the same cycle, from software or from a response, wins over the request.
- R4: Suppose a clock edge samples `cyc_n`=0, `xfer_n`=0, `fc`=7 and `addr_type`=15. Suppose also that the level {`addr_lvl`,`lock_a1`} equals the card's level code (3'b010 for level 2, 3'b110 for level 6), an interrupt is pending and vectored mode is on. Then `claim_n` is low in the following cycle.
- R5: A wrong function code, a wrong cycle type, the other supported level or any reserved level (0, 1, 3, 4, 5, 7) never produces a claim.
- R6: With vectored mode off, no acknowledge cycle is ever claimed.
- R7: While `cyc_n` is high, no claim is made, whatever the other lines show. The cycle after `cyc_n` is sampled high, `claim_n` is high and both output enables are low.
- R8: The cycle after `xfer_n` is sampled high during a claim, `claim_n` returns high. The card remains engaged in the cycle until `cyc_n` rises.
- R9: Once engaged and released, the card may be sampled with `sel_n`=0, `xfer_n`=0 and `dstrb0_n`=0. One cycle later `data_o` carries the vector on bits 15..8 with zeros elsewhere, and `data_oe`=1, `ack_oe`=1 and `ack_n`=0.
- R10: The response is held until `cyc_n` is sampled high. At all other times `data_oe` and `ack_oe` are low, `ack_n` is high and `data_o` is zero.
- R11: The response clears the pending interrupt, so the interrupt line is high in the same cycle that the response first appears.
- R12: Vector-phase selection of a card that did not claim the poll phase is ignored. No data, no acknowledge, and the interrupt stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 8 | Register write data |
| irq_req | input | 1 | Interrupt request pulse from card logic |
| cyc_n | input | 1 | Bus cycle strobe, active low |
| xfer_n | input | 1 | Master transfer strobe, active low |
| fc | input | 3 | Function code |
| addr_type | input | 4 | Address bits 19..16, cycle type |
| addr_lvl | input | 2 | Address bits 3..2, upper level bits |
| lock_a1 | input | 1 | Address bit 1 carried on the lock line |
| sel_n | input | 1 | Vector-phase selection from controller, active low |
| dstrb0_n | input | 1 | Data strobe for byte 0, active low |
| int2_n | output | 1 | Level-2 interrupt line, active low |
| int6_n | output | 1 | Level-6 interrupt line, active low |
| claim_n | output | 1 | Poll-phase claim, active low |
| data_o | output | 32 | Data bus value, vector on bits 15..8 |
| data_oe | output | 1 | Data bus output enable |
| ack_n | output | 1 | Data acknowledge, active low |
| ack_oe | output | 1 | Data acknowledge output enable |

## Verification
Every result is due exactly one clock after the edge that samples its cause. This holds for the pending flag and interrupt line after a request or clear, for the claim after a matching poll, for its release after the transfer strobe rises, and for the vector and acknowledge after selection. It also holds for the shutdown after the cycle strobe rises. The bench keeps a behavioural model that advances on each rising edge from the inputs sampled there. It compares every output against that model on the following falling edge, so each result is checked in the first cycle it is due. Separate event flags record whether a claim or an acknowledge was ever seen in a scenario, and check that outcome against what the scenario calls for.

// File: rtl/vecirq_pkg.sv
package vecirq_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_POLL  = 2'd1,
    PH_WAIT  = 2'd2,
    PH_DRIVE = 2'd3
  } phase_e;

  localparam logic [2:0] FC_CPU_SPACE = 3'd7;
  localparam logic [3:0] CT_INT_ACK   = 4'hF;

  localparam int NUM_LVLS = 2;
  localparam int LSEL_W   = (NUM_LVLS > 1) ? $clog2(NUM_LVLS) : 1;

  localparam int REG_AW = 2;
  localparam logic [REG_AW-1:0] RA_VECTOR = 2'd0;
  localparam logic [REG_AW-1:0] RA_CTRL   = 2'd1;
  localparam logic [REG_AW-1:0] RA_CLEAR  = 2'd2;

  // bus level code carried by each selectable level slot
  function automatic logic [2:0] lvl_code(input int idx);
    case (idx)
      0:       return 3'd2;
      1:       return 3'd6;
      default: return 3'd0;
    endcase
  endfunction

endpackage

// File: rtl/vecirq_regs.sv
module vecirq_regs
  import vecirq_pkg::*;
#(
  parameter int VEC_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [VEC_W-1:0]  reg_wdata,
  input  logic              irq_req,
  input  logic              svc_clr,
  output logic [VEC_W-1:0]  vector,
  output logic              vec_en,
  output logic [LSEL_W-1:0] lvl_sel,
  output logic              pending,
  output logic [NUM_LVLS-1:0] int_n
);

  logic [VEC_W-1:0]    vec_q;
  logic                en_q;
  logic [LSEL_W-1:0]   lvl_q, lvl_d;
  logic                pend_q, pend_d;
  logic [NUM_LVLS-1:0] int_q, int_d;
  logic                wr_vec, wr_ctl, wr_clr, clr_any;

  assign wr_vec  = reg_we && (reg_addr == RA_VECTOR);
  assign wr_ctl  = reg_we && (reg_addr == RA_CTRL);
  assign wr_clr  = reg_we && (reg_addr == RA_CLEAR);
  assign clr_any = wr_clr || svc_clr;

  always_comb begin
    if (clr_any)      pend_d = 1'b0;
    else if (irq_req) pend_d = 1'b1;
    else              pend_d = pend_q;
    lvl_d = wr_ctl ? reg_wdata[1 +: LSEL_W] : lvl_q;
  end

  generate
    for (genvar i = 0; i < NUM_LVLS; i++) begin : g_line
      assign int_d[i] = ~(pend_d && (lvl_d == LSEL_W'(i)));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      vec_q  <= '0;
      en_q   <= 1'b0;
      lvl_q  <= '0;
      pend_q <= 1'b0;
      int_q  <= '1;
    end else begin
      if (wr_vec) vec_q <= reg_wdata;
      if (wr_ctl) en_q  <= reg_wdata[0];
      lvl_q  <= lvl_d;
      pend_q <= pend_d;
      int_q  <= int_d;
    end
  end

  assign vector  = vec_q;
  assign vec_en  = en_q;
  assign lvl_sel = lvl_q;
  assign pending = pend_q;
  assign int_n   = int_q;

  // R3
  pend_set_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_req && !svc_clr && !wr_clr) |=> pending);

  // R11
  svc_clear_chk: assert property (@(posedge clk) disable iff (rst)
    svc_clr |=> (!pending && (&int_n)));

endmodule

// File: rtl/vecirq_decode.sv
module vecirq_decode
  import vecirq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cyc_n,
  input  logic              xfer_n,
  input  logic [2:0]        fc,
  input  logic [3:0]        addr_type,
  input  logic [2:0]        lvl_bus,
  input  logic [LSEL_W-1:0] lvl_sel,
  input  logic              pending,
  input  logic              vec_en,
  output logic              hit
);

  logic [NUM_LVLS-1:0] lvl_hit;
  logic                space_ok, armed;

  generate
    for (genvar i = 0; i < NUM_LVLS; i++) begin : g_lvl
      assign lvl_hit[i] = (lvl_sel == LSEL_W'(i)) && (lvl_bus == lvl_code(i));
    end
  endgenerate

  assign space_ok = !cyc_n && !xfer_n &&
                    (fc == FC_CPU_SPACE) && (addr_type == CT_INT_ACK);
  assign armed    = pending && vec_en;
  assign hit      = space_ok && armed && (|lvl_hit);

  // R5
  level_chk: assert property (@(posedge clk) disable iff (rst)
    hit |-> ((lvl_bus == 3'd2) || (lvl_bus == 3'd6)));

endmodule

// File: rtl/vecirq_phase.sv
module vecirq_phase
  import vecirq_pkg::*;
#(
  parameter int VEC_W   = 8,
  parameter int BUS_W   = 32,
  parameter int LANE_LO = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cyc_n,
  input  logic             xfer_n,
  input  logic             sel_n,
  input  logic             dstrb0_n,
  input  logic             hit,
  input  logic             vec_en,
  input  logic [VEC_W-1:0] vector,
  output logic             serviced,
  output logic             claim_n,
  output logic [BUS_W-1:0] data_o,
  output logic             data_oe,
  output logic             ack_n,
  output logic             ack_oe
);

  phase_e           phase_q, phase_d;
  logic             sel_ok, drive_d;
  logic [BUS_W-1:0] lane;
  logic             claim_q, oe_q, ack_q, ackoe_q;
  logic [BUS_W-1:0] data_q;

  assign sel_ok = !sel_n && !xfer_n && !dstrb0_n;

  always_comb begin
    phase_d = phase_q;
    if (cyc_n) begin
      phase_d = PH_IDLE;
    end else begin
      case (phase_q)
        PH_IDLE:  if (hit)    phase_d = PH_POLL;
        PH_POLL:  if (xfer_n) phase_d = PH_WAIT;
        PH_WAIT:  if (sel_ok) phase_d = PH_DRIVE;
        default:              phase_d = phase_q;
      endcase
    end
  end

  assign serviced = (phase_q == PH_WAIT) && !cyc_n && sel_ok;
  assign drive_d  = (phase_d == PH_DRIVE);

  always_comb begin
    lane = '0;
    lane[LANE_LO +: VEC_W] = vector;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      claim_q <= 1'b1;
      data_q  <= '0;
      oe_q    <= 1'b0;
      ack_q   <= 1'b1;
      ackoe_q <= 1'b0;
    end else begin
      phase_q <= phase_d;
      claim_q <= !(phase_d == PH_POLL);
      data_q  <= drive_d ? lane : '0;
      oe_q    <= drive_d;
      ack_q   <= !drive_d;
      ackoe_q <= drive_d;
    end
  end

  assign claim_n = claim_q;
  assign data_o  = data_q;
  assign data_oe = oe_q;
  assign ack_n   = ack_q;
  assign ack_oe  = ackoe_q;

  // R6
  autovec_chk: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_IDLE && !vec_en) |=> claim_n);

  // R7
  gate_chk: assert property (@(posedge clk) disable iff (rst)
    cyc_n |=> (claim_n && !data_oe && !ack_oe));

  // R8
  release_chk: assert property (@(posedge clk) disable iff (rst)
    (!claim_n && xfer_n) |=> claim_n);

  // R9
  prompt_chk: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_WAIT && !cyc_n && sel_ok) |=> (ack_oe && !ack_n && data_oe));

  // R12
  no_stray_chk: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_IDLE) |=> !ack_oe);

endmodule

// File: rtl/vecirq_responder.sv
module vecirq_responder
  import vecirq_pkg::*;
#(
  parameter int VEC_W   = 8,
  parameter int BUS_W   = 32,
  parameter int LANE_LO = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [VEC_W-1:0]  reg_wdata,
  input  logic              irq_req,
  input  logic              cyc_n,
  input  logic              xfer_n,
  input  logic [2:0]        fc,
  input  logic [3:0]        addr_type,
  input  logic [1:0]        addr_lvl,
  input  logic              lock_a1,
  input  logic              sel_n,
  input  logic              dstrb0_n,
  output logic              int2_n,
  output logic              int6_n,
  output logic              claim_n,
  output logic [BUS_W-1:0]  data_o,
  output logic              data_oe,
  output logic              ack_n,
  output logic              ack_oe
);

  logic [VEC_W-1:0]    vector;
  logic                vec_en, pending, hit, serviced;
  logic [LSEL_W-1:0]   lvl_sel;
  logic [NUM_LVLS-1:0] int_n;

  vecirq_regs #(.VEC_W(VEC_W)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .irq_req   (irq_req),
    .svc_clr   (serviced),
    .vector    (vector),
    .vec_en    (vec_en),
    .lvl_sel   (lvl_sel),
    .pending   (pending),
    .int_n     (int_n)
  );

  vecirq_decode u_decode (
    .clk       (clk),
    .rst       (rst),
    .cyc_n     (cyc_n),
    .xfer_n    (xfer_n),
    .fc        (fc),
    .addr_type (addr_type),
    .lvl_bus   ({addr_lvl, lock_a1}),
    .lvl_sel   (lvl_sel),
    .pending   (pending),
    .vec_en    (vec_en),
    .hit       (hit)
  );

  vecirq_phase #(
    .VEC_W   (VEC_W),
    .BUS_W   (BUS_W),
    .LANE_LO (LANE_LO)
  ) u_phase (
    .clk      (clk),
    .rst      (rst),
    .cyc_n    (cyc_n),
    .xfer_n   (xfer_n),
    .sel_n    (sel_n),
    .dstrb0_n (dstrb0_n),
    .hit      (hit),
    .vec_en   (vec_en),
    .vector   (vector),
    .serviced (serviced),
    .claim_n  (claim_n),
    .data_o   (data_o),
    .data_oe  (data_oe),
    .ack_n    (ack_n),
    .ack_oe   (ack_oe)
  );

  assign int2_n = int_n[0];
  assign int6_n = int_n[1];

endmodule

// File: tb/vecirq_responder_tb.sv
module vecirq_responder_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic        irq_req = 1'b0;
  logic        cyc_n = 1'b1, xfer_n = 1'b1, sel_n = 1'b1, dstrb0_n = 1'b1;
  logic [2:0]  fc = '0;
  logic [3:0]  addr_type = '0;
  logic [1:0]  addr_lvl = '0;
  logic        lock_a1 = 1'b0;
  logic        int2_n, int6_n, claim_n, data_oe, ack_n, ack_oe;
  logic [31:0] data_o;

  vecirq_responder u_dut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .irq_req(irq_req), .cyc_n(cyc_n),
    .xfer_n(xfer_n), .fc(fc), .addr_type(addr_type), .addr_lvl(addr_lvl),
    .lock_a1(lock_a1), .sel_n(sel_n), .dstrb0_n(dstrb0_n),
    .int2_n(int2_n), .int6_n(int6_n), .claim_n(claim_n), .data_o(data_o),
    .data_oe(data_oe), .ack_n(ack_n), .ack_oe(ack_oe)
  );

  always #4 clk = ~clk;

  int    n_cmp = 0, n_bad = 0, n_cyc = 0;
  string cur_req = "R1";
  bit    chk_en = 1'b0;
  bit    seen_claim = 1'b0, seen_ack = 1'b0;

  // behavioural reference state
  bit [7:0]  m_vec;
  bit        m_en, m_lvl6, m_pend;
  int        m_st;
  bit        e_int2, e_int6, e_claim, e_oe, e_ack, e_ackoe;
  bit [31:0] e_data;

  task automatic check(string r, string nm, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", r, nm, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (rst) begin
      m_vec = 0; m_en = 0; m_lvl6 = 0; m_pend = 0; m_st = 0;
      e_claim = 1; e_oe = 0; e_ack = 1; e_ackoe = 0; e_data = 0;
      e_int2 = 1; e_int6 = 1;
    end else begin
      bit sel, hit, svc, clr;
      int nxt, my_lvl;
      my_lvl = m_lvl6 ? 6 : 2;
      sel = !sel_n && !xfer_n && !dstrb0_n;
      hit = !cyc_n && !xfer_n && fc == 3'd7 && addr_type == 4'd15 &&
            int'({addr_lvl, lock_a1}) == my_lvl && m_pend && m_en;
      svc = (m_st == 2) && sel && !cyc_n;
      if (cyc_n) nxt = 0;
      else if (m_st == 0) nxt = hit ? 1 : 0;
      else if (m_st == 1) nxt = xfer_n ? 2 : 1;
      else if (m_st == 2) nxt = sel ? 3 : 2;
      else nxt = 3;
      e_claim = (nxt != 1);
      e_oe    = (nxt == 3);
      e_ackoe = (nxt == 3);
      e_ack   = (nxt != 3);
      e_data  = (nxt == 3) ? {16'd0, m_vec, 8'd0} : 32'd0;
      m_st = nxt;
      if (reg_we && reg_addr == 2'd0) m_vec = reg_wdata;
      if (reg_we && reg_addr == 2'd1) begin m_en = reg_wdata[0]; m_lvl6 = reg_wdata[1]; end
      clr = svc || (reg_we && reg_addr == 2'd2);
      if (clr) m_pend = 0;
      else if (irq_req) m_pend = 1;
      e_int2 = !(m_pend && !m_lvl6);
      e_int6 = !(m_pend && m_lvl6);
    end
  end

  always @(negedge clk) begin
    if (chk_en) begin
      check(cur_req, "int2_n", int2_n, e_int2);
      check(cur_req, "int6_n", int6_n, e_int6);
      check(cur_req, "claim_n", claim_n, e_claim);
      check(cur_req, "data_o", data_o, e_data);
      check(cur_req, "data_oe", data_oe, e_oe);
      check(cur_req, "ack_n", ack_n, e_ack);
      check(cur_req, "ack_oe", ack_oe, e_ackoe);
      if (!claim_n) seen_claim = 1'b1;
      if (ack_oe && !ack_n) seen_ack = 1'b1;
    end
  end

  always @(posedge clk) begin
    n_cyc++;
    if (n_cyc > 100000) begin
      n_bad++;
      $display("FAIL watchdog expired after %0d cycles", n_cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic pulse_irq();
    irq_req = 1;
    @(negedge clk);
    irq_req = 0;
  endtask

  task automatic iack(input logic [2:0] f, input logic [3:0] ct,
                      input logic [2:0] lv, input bit do_poll);
    seen_claim = 0; seen_ack = 0;
    cyc_n = 0;
    if (do_poll) begin
      xfer_n = 0; fc = f; addr_type = ct; {addr_lvl, lock_a1} = lv;
      repeat (2) @(negedge clk);
      xfer_n = 1; fc = 0; addr_type = 0; {addr_lvl, lock_a1} = 3'd0;
      repeat (2) @(negedge clk);
    end
    sel_n = 0; xfer_n = 0; dstrb0_n = 0;
    repeat (3) @(negedge clk);
    cyc_n = 1; xfer_n = 1; sel_n = 1; dstrb0_n = 1;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", "int2_n", int2_n, 1);
    check("R1", "int6_n", int6_n, 1);
    check("R1", "claim_n", claim_n, 1);
    check("R1", "data_oe", data_oe, 0);
    check("R1", "ack_oe", ack_oe, 0);
    check("R1", "ack_n", ack_n, 1);
    check("R1", "data_o", data_o, 0);
    rst = 0;
    chk_en = 1;
    @(negedge clk);

    cur_req = "R2";
    wr(2'd0, 8'hA5);
    wr(2'd1, 8'h01);
    wr(2'd3, 8'hFF);

    cur_req = "R3";
    pulse_irq();
    check("R3", "int2_n low", int2_n, 0);
    check("R3", "int6_n high", int6_n, 1);

    cur_req = "R4";
    iack(3'd7, 4'd15, 3'd2, 1);
    check("R4", "claim seen", seen_claim, 1);
    check("R9", "ack seen", seen_ack, 1);
    cur_req = "R11";
    check("R11", "int2_n released", int2_n, 1);

    cur_req = "R5";
    pulse_irq();
    iack(3'd5, 4'd15, 3'd2, 1);
    check("R5", "no claim wrong fc", seen_claim, 0);
    iack(3'd7, 4'd14, 3'd2, 1);
    check("R5", "no claim wrong type", seen_claim, 0);
    iack(3'd7, 4'd15, 3'd6, 1);
    check("R5", "no claim other level", seen_claim, 0);
    iack(3'd7, 4'd15, 3'd3, 1);
    check("R5", "no claim reserved", seen_claim, 0);
    check("R5", "still pending", int2_n, 0);

    cur_req = "R12";
    iack(3'd7, 4'd15, 3'd2, 0);
    check("R12", "no ack without claim", seen_ack, 0);
    check("R12", "still pending", int2_n, 0);

    cur_req = "R7";
    seen_claim = 0;
    xfer_n = 0; fc = 3'd7; addr_type = 4'd15; {addr_lvl, lock_a1} = 3'd2;
    repeat (3) @(negedge clk);
    xfer_n = 1; fc = 0; addr_type = 0; {addr_lvl, lock_a1} = 3'd0;
    @(negedge clk);
    check("R7", "no claim without cycle strobe", seen_claim, 0);

    cur_req = "R6";
    wr(2'd1, 8'h00);
    iack(3'd7, 4'd15, 3'd2, 1);
    check("R6", "no claim autovector", seen_claim, 0);

    cur_req = "R2";
    wr(2'd2, 8'h00);
    check("R2", "sw clear", int2_n, 1);
    wr(2'd0, 8'h3C);
    wr(2'd1, 8'h03);

    cur_req = "R3";
    irq_req = 1; reg_we = 1; reg_addr = 2'd2;
    @(negedge clk);
    irq_req = 0; reg_we = 0;
    check("R3", "clear wins", int6_n, 1);
    pulse_irq();
    check("R3", "int6_n low", int6_n, 0);
    check("R3", "int2_n high", int2_n, 1);

    cur_req = "R8";
    iack(3'd7, 4'd15, 3'd2, 1);
    check("R8", "level2 not claimed at level6", seen_claim, 0);
    cur_req = "R9";
    iack(3'd7, 4'd15, 3'd6, 1);
    check("R9", "claim seen level6", seen_claim, 1);
    check("R9", "ack seen level6", seen_ack, 1);
    cur_req = "R10";
    check("R10", "bus idle after cycle", data_oe, 0);
    check("R10", "ack idle after cycle", ack_oe, 0);
    check("R11", "int6_n released", int6_n, 1);

    repeat (4) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule